// File: doc/BRIEF.md
# Dual-Channel Power-Good Monitor

This block produces the single power-good flag shared by both channels of a two-channel regulator controller. For each channel it receives three digital flags: a window flag that says whether the monitored output voltage lies inside its regulation band, a soft-start-done flag, and an enable flag that goes low when the channel is disabled or has faulted. An overvoltage trip strobe stands for the protection latch. A low power-good output models the open-drain pull-down.

Window faults are qualified on a switching-clock strobe `tick`. This strobe is high for one system-clock cycle per switching period. A window fault on either channel must be seen on three consecutive strobes before it pulls power-good low. A single in-window strobe clears that qualification again. Power-good is high only when all of the following hold: both soft-starts are done, both enables are high, no qualified window fault is pending, and no overvoltage trip has been seen since reset.

Top module: `pg_monitor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after its release, `pg` is 0 and the consecutive-fault count is zero.
- R2: `pg` is 0 in the cycle after any cycle in which either bit of `ss_done` is 0 (bit i = 1 means channel i finished soft-start).
- R3: A window fault on either channel (bit i of `win_ok` = 0 means channel i is out of its window) present on three consecutive `tick` cycles drives `pg` to 0 in the cycle after the third such tick.
- R4: A `tick` cycle with both `win_ok` bits at 1 clears the fault count, so faults separated by such a tick are never combined into three.
- R5: After a qualified window fault, `pg` returns to 1 one cycle after the first `tick` with both `win_ok` bits at 1, provided both soft-starts are done and both enables are high.
- R6: Cycles with `tick` at 0 neither advance nor clear the fault count, whatever `win_ok` holds.
- R7: `pg` is 0 in the cycle after any cycle in which either bit of `en_ok` is 0 (bit i = 1 means channel i is enabled).
- R8: A cycle with `ov_trip` at 1 forces `pg` to 0 from the next cycle on until the next reset, regardless of all other inputs.
- R9: With every condition met, `pg` is 1 one system-clock cycle after the inputs settle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle switching-clock strobe |
| win_ok | input | CH | Per-channel in-window flag, 1 = in regulation |
| ss_done | input | CH | Per-channel soft-start complete flag |
| en_ok | input | CH | Per-channel enable/fault line, 1 = enabled |
| ov_trip | input | 1 | Overvoltage latch request |
| pg | output | 1 | Shared power-good, 0 = pulled low |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `tick` is a single-cycle strobe. They also assume that a falling `pg` which is not explained by soft-start, enable or overvoltage must come from a bad-window tick. The stimulus changes every input only on the falling clock edge. It drives `tick` either as a continuous strobe or holds it low for stretches, so the count-hold case is exercised without breaking those assumptions. Window faults are applied on each channel separately, in runs of two and three broken by single good ticks.

// File: rtl/pg_monitor.sv
module pg_monitor #(
  parameter int CH          = 2,
  parameter int FAULT_TICKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CH-1:0] win_ok,
  input  logic [CH-1:0] ss_done,
  input  logic [CH-1:0] en_ok,
  input  logic          ov_trip,
  output logic          pg
);
  localparam int CW = $clog2(FAULT_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(FAULT_TICKS);

  logic [CW-1:0] cnt, cnt_nx;
  logic          ov_lat;
  logic          ov_nx;
  logic          pg_nx;

  always_comb begin
    cnt_nx = cnt;
    if (tick) begin
      if (&win_ok)         cnt_nx = '0;
      else if (cnt != LIM) cnt_nx = cnt + 1'b1;
    end
  end

  assign ov_nx = ov_lat | ov_trip;
  assign pg_nx = ~ov_nx & (&ss_done) & (&en_ok) & (cnt_nx != LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      ov_lat <= 1'b0;
      pg     <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      ov_lat <= ov_nx;
      pg     <= pg_nx;
    end
  end
endmodule

module pg_monitor_chk #(
  parameter int CH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [CH-1:0] win_ok,
  input logic [CH-1:0] ss_done,
  input logic [CH-1:0] en_ok,
  input logic          ov_trip,
  input logic          pg
);
  logic seen_ov;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_ov <= 1'b0;
    else if (ov_trip) seen_ov <= 1'b1;

  always_comb
    if (!rst_n) assert_reset_low_R1: assert (!pg);

  assert_ss_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(&ss_done) |=> !pg);

  assert_en_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(&en_ok) |=> !pg);

  assert_ov_now_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ov_trip |=> !pg);

  assert_ov_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seen_ov |-> !pg);

  assert_fault_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pg) && $past(&ss_done) && $past(&en_ok) && !$past(ov_trip))
      |-> ($past(tick) && !$past(&win_ok)));
endmodule

bind pg_monitor pg_monitor_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .win_ok(win_ok),
  .ss_done(ss_done), .en_ok(en_ok), .ov_trip(ov_trip), .pg(pg)
);

// File: tb/pg_monitor_test.sv
module pg_monitor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] win_ok = 2'b11;
  logic [1:0] ss_done = 2'b00;
  logic [1:0] en_ok = 2'b11;
  logic       ov_trip = 1'b0;
  logic       pg;

  int errors = 0;
  int checks = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pg_monitor uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .win_ok(win_ok),
    .ss_done(ss_done), .en_ok(en_ok), .ov_trip(ov_trip), .pg(pg)
  );

  task automatic check(input bit exp, input string tag);
    checks++;
    if (pg !== exp) begin
      errors++;
      $display("FAIL %s: pg=%b expected %b at %0t", tag, pg, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] w, input logic [1:0] s, input logic [1:0] e,
                      input logic o, input logic t, input bit exp, input string tag);
    @(negedge clk);
    win_ok = w; ss_done = s; en_ok = e; ov_trip = o; tick = t;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, got hang expected end");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 during reset");
    rst_n = 1'b1;
    step(2'b11, 2'b00, 2'b11, 0, 1, 0, "R1 after release");
    step(2'b11, 2'b01, 2'b11, 0, 1, 0, "R2 ch1 soft-start pending");
    step(2'b11, 2'b10, 2'b11, 0, 1, 0, "R2 ch0 soft-start pending");
    step(2'b11, 2'b11, 2'b11, 0, 1, 1, "R9 all good");
    step(2'b10, 2'b11, 2'b11, 0, 1, 1, "R3 ch0 fault tick 1");
    step(2'b10, 2'b11, 2'b11, 0, 1, 1, "R3 ch0 fault tick 2");
    step(2'b10, 2'b11, 2'b11, 0, 1, 0, "R3 ch0 fault tick 3");
    step(2'b10, 2'b11, 2'b11, 0, 1, 0, "R3 fault persists");
    step(2'b11, 2'b11, 2'b11, 0, 1, 1, "R5 recovery");
    step(2'b10, 2'b11, 2'b11, 0, 1, 1, "R4 bad 1");
    step(2'b10, 2'b11, 2'b11, 0, 1, 1, "R4 bad 2");
    step(2'b11, 2'b11, 2'b11, 0, 1, 1, "R4 good clears");
    step(2'b10, 2'b11, 2'b11, 0, 1, 1, "R4 bad 1 again");
    step(2'b10, 2'b11, 2'b11, 0, 1, 1, "R4 bad 2 again");
    step(2'b10, 2'b11, 2'b11, 0, 1, 0, "R4 third after clear");
    step(2'b11, 2'b11, 2'b11, 0, 1, 1, "R5 recovery again");
    step(2'b01, 2'b11, 2'b11, 0, 1, 1, "R6 ch1 bad tick 1");
    for (int i = 0; i < 5; i++)
      step(2'b01, 2'b11, 2'b11, 0, 0, 1, "R6 no tick holds count");
    step(2'b01, 2'b11, 2'b11, 0, 1, 1, "R6 ch1 bad tick 2");
    for (int i = 0; i < 3; i++)
      step(2'b11, 2'b11, 2'b11, 0, 0, 1, "R6 good without tick no clear");
    step(2'b01, 2'b11, 2'b11, 0, 1, 0, "R3 ch1 bad tick 3");
    step(2'b01, 2'b11, 2'b11, 0, 0, 0, "R6 fault held without tick");
    step(2'b11, 2'b11, 2'b11, 0, 1, 1, "R5 recovery ch1");
    step(2'b11, 2'b11, 2'b10, 0, 1, 0, "R7 ch0 disabled");
    step(2'b11, 2'b11, 2'b11, 0, 1, 1, "R7 ch0 re-enabled");
    step(2'b11, 2'b11, 2'b01, 0, 0, 0, "R7 ch1 disabled");
    step(2'b11, 2'b11, 2'b11, 0, 0, 1, "R7 ch1 re-enabled");
    step(2'b11, 2'b10, 2'b11, 0, 1, 0, "R2 soft-start dropped");
    step(2'b11, 2'b11, 2'b11, 0, 1, 1, "R2 soft-start back");
    step(2'b11, 2'b11, 2'b11, 1, 1, 0, "R8 ov trip");
    for (int i = 0; i < 4; i++)
      step(2'b11, 2'b11, 2'b11, 0, 1, 0, "R8 latched low");
    step(2'b11, 2'b11, 2'b11, 0, 0, 0, "R8 latched low no tick");
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(1'b0, "R1 reset after latch");
    rst_n = 1'b1;
    step(2'b11, 2'b11, 2'b11, 0, 1, 1, "R8 reset clears latch");
    step(2'b10, 2'b11, 2'b11, 0, 1, 1, "R1 count cleared, bad 1");
    step(2'b11, 2'b11, 2'b11, 0, 1, 1, "R1 good after bad");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule